// File: doc/BRIEF.md
# Dual-Edge Operand Register Bank

This block sits in front of a 32-bit arithmetic datapath and holds its operands. There are eight operand words: four on the A side and four on the B side. Each word has its own load enable, so one input word can land in several registers at once. Two read multiplexers each pick one register per side and pass it to the datapath. Each read can also clear the sign bit, which gives the absolute value of a floating-point operand.

In two-port mode, A words come from `port_a` and B words come from `port_b`. Both are captured on the rising clock edge. In single-port mode, `port_a` carries both streams. A words are taken at the rising edge and B words at the following falling edge. The B load enables for that falling edge are sampled at the rising edge before it, so every control changes only once per cycle.

Read selects and absolute-value requests are registered at the rising edge. The operand outputs are combinational from the registers. A word loaded at a rising edge is therefore on the operand output right after that same edge when it is also selected there, with no extra cycle.

Top module: `opbank_top`

## Requirements
- R1: An active-low `rst_n` immediately clears all eight registers, both read selects and both absolute-value requests. While it is low, and after it is released with no loads, every selectable word reads as zero.
- R2: At a rising edge, each A register whose bit in `ld_a` is 1 takes the value on `port_a`. A registers whose bit is 0 keep their value. Bit k of `ld_a` belongs to register k.
- R3: Several load bits set together write the same input word into every selected register in the same edge, on either side.
- R4: With `single_port` low at a rising edge, each B register whose bit in `ld_b` is 1 takes the value on `port_b`. Bit k belongs to register k.
- R5: With `single_port` high at a rising edge, B registers are not written at that rising edge and `port_b` is ignored. At the next falling edge, each B register whose `ld_b` bit was 1 takes the value on `port_a`.
- R6: For a falling-edge load, only the `ld_b` value sampled at the preceding rising edge counts. Changing `ld_b` between that rising edge and the falling edge has no effect on which B registers are written.
- R7: `rd_a` and `rd_b` are 2-bit register indices (0 to 3) sampled at the rising edge. After that edge, `opnd_a` and `opnd_b` show the selected A and B register.
- R8: A register that is loaded and selected at the same rising edge shows its new value on the operand output immediately after that edge.
- R9: When `abs_a` (or `abs_b`) is 1 at a rising edge, bit 31 of `opnd_a` (or `opnd_b`) reads 0 until the next rising edge. Bits 30:0 are unchanged. When the request is 0, the word passes through unaltered.
- R10: In single-port mode, a B register written at a falling edge shows its new value on `opnd_b` right after that falling edge, within the same cycle, when it is the selected B register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising and falling edges both capture data |
| rst_n | input | 1 | Asynchronous active-low reset |
| single_port | input | 1 | 1: `port_a` feeds both sides (B on falling edge); 0: two ports, rising edge |
| port_a | input | 32 | Input word for A registers, and for B registers in single-port mode |
| port_b | input | 32 | Input word for B registers in two-port mode |
| ld_a | input | 4 | Per-register load enables, A side |
| ld_b | input | 4 | Per-register load enables, B side |
| rd_a | input | 2 | A register index for the datapath |
| rd_b | input | 2 | B register index for the datapath |
| abs_a | input | 1 | Clear sign bit of the A operand |
| abs_b | input | 1 | Clear sign bit of the B operand |
| opnd_a | output | 32 | A operand to the datapath |
| opnd_b | output | 32 | B operand to the datapath |

## Verification
A corrupted register shows up only when it is selected. The bench therefore sweeps the read indices and mixes random selects, so a bad word reaches the operand port within a few cycles of being written. A falling-edge enable taken at the wrong time, or a rising/falling storage half that drifts, appears on `opnd_b` immediately after the falling edge. That window is checked every cycle, before the next rising edge can hide it. A stale read select or sign request is caught right after the rising edge that should have changed it.

// File: rtl/opbank_pkg.sv
package opbank_pkg;
  localparam int WORD_W = 32;
  localparam int NREGS  = 4;

  typedef logic [WORD_W-1:0] word_t;

  // Clear the most significant (sign) bit when requested.
  function automatic word_t clear_sign(input word_t w, input logic req);
    word_t r;
    r = w;
    if (req) r[WORD_W-1] = 1'b0;
    return r;
  endfunction

  // Rising-half update of a dual-edge pair: keeps q = rise ^ fall.
  function automatic word_t pair_encode(input word_t d, input word_t other);
    return d ^ other;
  endfunction
endpackage

// File: rtl/opbank_dcell.sv
module opbank_dcell
  import opbank_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rise_en,
  input  logic [W-1:0] rise_d,
  input  logic         fall_en,
  input  logic [W-1:0] fall_d,
  output logic [W-1:0] q
);
  // Two single-edge halves whose XOR is the stored word.
  logic [W-1:0] half_r;
  logic [W-1:0] half_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       half_r <= '0;
    else if (rise_en) half_r <= rise_d ^ half_f;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)       half_f <= '0;
    else if (fall_en) half_f <= fall_d ^ half_r;
  end

  assign q = half_r ^ half_f;
endmodule

// File: rtl/opbank_bank.sv
module opbank_bank
  import opbank_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int N = NREGS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        rise_en,
  input  logic [W-1:0]        rise_d,
  input  logic [N-1:0]        fall_en,
  input  logic [W-1:0]        fall_d,
  output logic [N-1:0][W-1:0] regs
);
  for (genvar k = 0; k < N; k++) begin : g_cell
    opbank_dcell #(.W(W)) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise_en (rise_en[k]),
      .rise_d  (rise_d),
      .fall_en (fall_en[k]),
      .fall_d  (fall_d),
      .q       (regs[k])
    );
  end
endmodule

// File: rtl/opbank_rdsel.sv
module opbank_rdsel
  import opbank_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int N = NREGS,
  localparam int SW = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SW-1:0]       sel,
  input  logic                abs_req,
  input  logic [N-1:0][W-1:0] regs,
  output logic [SW-1:0]       sel_q,
  output logic                abs_q,
  output logic [W-1:0]        opnd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      abs_q <= 1'b0;
    end else begin
      sel_q <= sel;
      abs_q <= abs_req;
    end
  end

  // Combinational after the registered select: same-edge feed-through.
  assign opnd = clear_sign(regs[sel_q], abs_q);
endmodule

// File: rtl/opbank_top.sv
module opbank_top
  import opbank_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int N = NREGS,
  localparam int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          single_port,
  input  logic [W-1:0]  port_a,
  input  logic [W-1:0]  port_b,
  input  logic [N-1:0]  ld_a,
  input  logic [N-1:0]  ld_b,
  input  logic [SW-1:0] rd_a,
  input  logic [SW-1:0] rd_b,
  input  logic          abs_a,
  input  logic          abs_b,
  output logic [W-1:0]  opnd_a,
  output logic [W-1:0]  opnd_b
);
  // Named internal events for the checker.
  logic [N-1:0]        a_rise_en;
  logic [N-1:0]        b_rise_en;
  logic [N-1:0]        b_fall_en;   // sampled at rising edge, used at falling edge
  logic [N-1:0][W-1:0] a_regs;
  logic [N-1:0][W-1:0] b_regs;
  logic [SW-1:0]       rd_a_q;
  logic [SW-1:0]       rd_b_q;
  logic                abs_a_q;
  logic                abs_b_q;

  assign a_rise_en = ld_a;
  assign b_rise_en = single_port ? '0 : ld_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) b_fall_en <= '0;
    else        b_fall_en <= single_port ? ld_b : '0;
  end

  opbank_bank #(.W(W), .N(N)) u_bank_a (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise_en (a_rise_en),
    .rise_d  (port_a),
    .fall_en ('0),
    .fall_d  ('0),
    .regs    (a_regs)
  );

  opbank_bank #(.W(W), .N(N)) u_bank_b (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise_en (b_rise_en),
    .rise_d  (port_b),
    .fall_en (b_fall_en),
    .fall_d  (port_a),
    .regs    (b_regs)
  );

  opbank_rdsel #(.W(W), .N(N)) u_rd_a (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (rd_a),
    .abs_req (abs_a),
    .regs    (a_regs),
    .sel_q   (rd_a_q),
    .abs_q   (abs_a_q),
    .opnd    (opnd_a)
  );

  opbank_rdsel #(.W(W), .N(N)) u_rd_b (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (rd_b),
    .abs_req (abs_b),
    .regs    (b_regs),
    .sel_q   (rd_b_q),
    .abs_q   (abs_b_q),
    .opnd    (opnd_b)
  );
endmodule

// File: rtl/opbank_chk.sv
module opbank_chk #(
  parameter int W = 32,
  parameter int N = 4,
  localparam int SW = $clog2(N)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [W-1:0]        port_a,
  input logic [W-1:0]        port_b,
  input logic [SW-1:0]       rd_a,
  input logic [SW-1:0]       rd_b,
  input logic [N-1:0]        a_rise_en,
  input logic [N-1:0]        b_rise_en,
  input logic [N-1:0]        b_fall_en,
  input logic [N-1:0][W-1:0] a_regs,
  input logic [N-1:0][W-1:0] b_regs,
  input logic [SW-1:0]       rd_a_q,
  input logic [SW-1:0]       rd_b_q,
  input logic                abs_a_q,
  input logic                abs_b_q,
  input logic [W-1:0]        opnd_a,
  input logic [W-1:0]        opnd_b
);
  // Set one rising edge after reset release, so $past never reaches into reset.
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  logic [W-1:0] fall_word;
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_word <= '0;
    else        fall_word <= port_a;
  end

  for (genvar k = 0; k < N; k++) begin : g_reg
    p_a_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(a_rise_en[k]) |-> a_regs[k] == $past(port_a));
    p_a_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      armed && !$past(a_rise_en[k]) |-> a_regs[k] == $past(a_regs[k]));
    p_b_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(b_rise_en[k]) |-> b_regs[k] == $past(port_b));
    p_b_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      armed && b_fall_en[k] |-> b_regs[k] == fall_word);
  end

  p_rd_a_reg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> rd_a_q == $past(rd_a));
  p_rd_b_reg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> rd_b_q == $past(rd_b));
  p_abs_a_sign_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abs_a_q |-> !opnd_a[W-1]);
  p_abs_b_sign_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abs_b_q |-> !opnd_b[W-1]);
endmodule

bind opbank_top opbank_chk #(.W(W), .N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .port_a    (port_a),
  .port_b    (port_b),
  .rd_a      (rd_a),
  .rd_b      (rd_b),
  .a_rise_en (a_rise_en),
  .b_rise_en (b_rise_en),
  .b_fall_en (b_fall_en),
  .a_regs    (a_regs),
  .b_regs    (b_regs),
  .rd_a_q    (rd_a_q),
  .rd_b_q    (rd_b_q),
  .abs_a_q   (abs_a_q),
  .abs_b_q   (abs_b_q),
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b)
);

// File: tb/opbank_top_test.sv
module opbank_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        single_port = 1'b0;
  logic [31:0] port_a = '0;
  logic [31:0] port_b = '0;
  logic [3:0]  ld_a = '0;
  logic [3:0]  ld_b = '0;
  logic [1:0]  rd_a = '0;
  logic [1:0]  rd_b = '0;
  logic        abs_a = 1'b0;
  logic        abs_b = 1'b0;
  logic [31:0] opnd_a;
  logic [31:0] opnd_b;

  int errors = 0;
  int checks = 0;

  // Reference model state.
  logic [31:0] mA [4];
  logic [31:0] mB [4];
  logic [1:0]  mrd_a, mrd_b;
  logic        mabs_a, mabs_b;
  logic [3:0]  mpend;

  opbank_top uut (
    .clk(clk), .rst_n(rst_n), .single_port(single_port),
    .port_a(port_a), .port_b(port_b), .ld_a(ld_a), .ld_b(ld_b),
    .rd_a(rd_a), .rd_b(rd_b), .abs_a(abs_a), .abs_b(abs_b),
    .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] view(input logic [31:0] w, input logic strip);
    return strip ? (w & 32'h7fff_ffff) : w;
  endfunction

  task automatic chk(input string tg, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got=%h expected=%h at %0t", tg, got, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 4; i++) begin mA[i] = '0; mB[i] = '0; end
    mrd_a = '0; mrd_b = '0; mabs_a = 0; mabs_b = 0; mpend = '0;
  endtask

  // Called just after a falling edge; runs one full cycle.
  task automatic cycle(input string tg, input logic sp,
                       input logic [31:0] pa, input logic [31:0] pb,
                       input logic [3:0] la, input logic [3:0] lb,
                       input logic [1:0] ra, input logic [1:0] rb,
                       input logic aa, input logic ab,
                       input logic [31:0] fall_d);
    single_port = sp; port_a = pa; port_b = pb; ld_a = la; ld_b = lb;
    rd_a = ra; rd_b = rb; abs_a = aa; abs_b = ab;
    @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      if (la[i]) mA[i] = pa;
      if (!sp && lb[i]) mB[i] = pb;
    end
    mrd_a = ra; mrd_b = rb; mabs_a = aa; mabs_b = ab;
    mpend = sp ? lb : 4'b0000;
    #1;
    port_a = fall_d;
    ld_b   = ~lb;                 // R6: late change must not matter
    port_b = $urandom;            // R5: ignored in single-port mode
    #1;
    chk({tg, " opnd_a after rise"}, opnd_a, view(mA[mrd_a], mabs_a));
    chk({tg, " opnd_b after rise"}, opnd_b, view(mB[mrd_b], mabs_b));
    @(negedge clk);
    for (int i = 0; i < 4; i++) if (mpend[i]) mB[i] = fall_d;
    #1;
    chk({tg, " opnd_b after fall"}, opnd_b, view(mB[mrd_b], mabs_b));
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: got=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    model_clear();
    #3;
    chk("R1 opnd_a in reset", opnd_a, 32'h0);
    chk("R1 opnd_b in reset", opnd_b, 32'h0);
    @(negedge clk); #1;
    rst_n = 1'b1;

    // R3: broadcast writes on both sides
    cycle("R3", 0, 32'hC0DE_1234, 32'h8765_4321, 4'hF, 4'b1010, 0, 0, 0, 0, 32'h0);
    for (int i = 0; i < 4; i++)
      cycle("R3 R4 R7", 0, 32'h0, 32'h0, 4'h0, 4'h0, i[1:0], i[1:0], 0, 0, 32'h0);

    // R8: load and select in the same edge
    cycle("R8 R2", 0, 32'hFACE_0002, 32'h1111_0003, 4'b0100, 4'b1000, 2, 3, 0, 0, 32'h0);

    // R5 R6 R10: single-port, falling-edge B capture, late ld_b flip
    cycle("R5 R10", 1, 32'h0A0A_0001, 32'hDEAD_BEEF, 4'b0010, 4'b0001, 1, 0, 0, 0, 32'hB0B0_5555);
    cycle("R6 R5", 1, 32'h0, 32'hDEAD_BEEF, 4'h0, 4'h0, 1, 2, 0, 0, 32'h7777_7777);
    cycle("R6", 0, 32'h0, 32'h0, 4'h0, 4'h0, 1, 0, 0, 0, 32'h0);

    // R9: absolute value on negative and positive words
    cycle("R9", 0, 32'hBF80_0000, 32'h4040_0000, 4'b0001, 4'b0001, 0, 0, 1, 1, 32'h0);
    cycle("R9", 0, 32'h0, 32'hC000_0001, 4'h0, 4'b0001, 0, 0, 0, 1, 32'h0);
    cycle("R9", 0, 32'h0, 32'h0, 4'h0, 4'h0, 0, 0, 0, 0, 32'h0);

    // Random mix across modes
    void'($urandom(32'h5eed_1234));
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      cycle("R2 R4 R5 R7 R9 R10", r[0], $urandom, $urandom, r[4:1], r[8:5],
            r[10:9], r[12:11], r[13], r[14], $urandom);
    end

    // R1: asynchronous reset in mid-run
    rst_n = 1'b0;
    #1;
    model_clear();
    chk("R1 opnd_a async clear", opnd_a, 32'h0);
    chk("R1 opnd_b async clear", opnd_b, 32'h0);
    @(negedge clk); #1;
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++)
      cycle("R1", 0, 32'h0, 32'h0, 4'h0, 4'h0, i[1:0], i[1:0], 0, 0, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule